// File: doc/BRIEF.md
# Sliding Cross-Correlation Delay Finder

This block estimates the delay between two equal-length sample records by evaluating their cross-correlation directly, one lag at a time, on a single multiply-accumulate unit. A paired sample stream fills two on-chip record buffers, one entry of each per accepted beat. A start pulse then launches a search over a programmable window of lags. For every lag the block multiplies the overlapping samples of the two records and sums the products. It keeps the lag whose sum is largest and reports that lag and its sum with a one-cycle done pulse.

For lag `L` the correlation is `C(L) = sum over i = 0 .. N-1-L of recA[i] * recB[i+L]`, so a positive lag means record B trails record A. A search costs exactly one cycle per product plus a fixed pipeline drain. With the default record length of 4096, a full sweep of every lag takes about 8.4 million cycles. That fits a 100 ms result interval at clock rates above roughly 85 MHz, which is well above the 10 MHz sample rate. The record length must be a power of two.

Top module: `xcorr_lag_finder`

## Requirements
- R1: While idle, every cycle with `ldValid` high writes `ldA` to record A and `ldB` to record B at the write pointer, which then advances by one and wraps from N-1 to 0; when `ldFirst` is high with `ldValid`, the pair goes to address 0 and the pointer continues from 1.
- R2: Load beats that arrive while `busy` is high write nothing: a later search over the same records gives the same result.
- R3: `bestCorr` is a signed value 2*W+log2(N) bits wide and holds the exact correlation sum, even when every sample is the most negative code.
- R4: After a search, `bestLag` is the lag in the searched window with the largest C(L), and `bestCorr` is that C(L).
- R5: When several lags share the largest value, the smallest of those lags is reported.
- R6: The first lag evaluated always seeds the peak, so a window in which every C(L) is negative reports the least negative one.
- R7: `minLag` and `maxLag` are sampled with the accepted start; the window is minLag..maxLag, and when maxLag is below minLag only minLag is evaluated.
- R8: A start pulse seen while idle raises `busy` in the next cycle; `busy` stays high until the cycle in which `done` is high, and start pulses seen while busy have no effect.
- R9: With the start pulse sampled in cycle s and T = sum over the window of (N-L) products, `done` is high for exactly one cycle, cycle s+T+4.
- R10: During and directly after reset, `busy`, `done`, `bestLag` and `bestCorr` are all zero.
- R11: While idle, `bestLag` and `bestCorr` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ldValid | input | 1 | Sample pair valid on the load stream |
| ldFirst | input | 1 | Marks the pair as the first of a record (address 0) |
| ldA | input | W | Signed sample for record A |
| ldB | input | W | Signed sample for record B |
| start | input | 1 | One-cycle pulse that launches a search |
| minLag | input | log2(N) | Lowest lag of the search window |
| maxLag | input | log2(N) | Highest lag of the search window |
| busy | output | 1 | High while a search is running |
| done | output | 1 | One-cycle pulse when the result is final |
| bestLag | output | log2(N) | Lag with the largest correlation |
| bestCorr | output | 2*W+log2(N) | Signed correlation at that lag |

## Verification
The bench aims at the peak tracker's corner cases. A tie between two lags would expose a greater-or-equal compare, because that compare reports the later lag. A window of all-negative sums would expose a tracker seeded with zero, because it reports lag 0 with a value of zero. A reversed window, and a window of one lag, would show a controller that overruns its end lag or never stops, and both appear as a wrong done cycle. Full-scale negative records would reveal a truncated accumulator as a wrapped sum. Start and load beats injected mid-search, together with a wrapped load, would catch a search that restarts, a buffer that is overwritten during a run, or a write pointer that fails to wrap or re-anchor.

// File: rtl/xcorr_pkg.sv
package xcorr_pkg;

  // Strobes from the sequencer to the datapath, one set per cycle.
  typedef struct packed {
    logic issue;      // a product term is read this cycle
    logic firstTerm;  // term is the first of its lag
    logic lastTerm;   // term is the last of its lag
    logic clearPeak;  // a new search begins: forget the stored peak
    logic loadEn;     // sample loading allowed (idle)
  } xcorrStrobes_t;

endpackage

// File: rtl/xcorr_buffer.sv
// One record store: single write port, registered read port.
module xcorr_buffer #(
  parameter int W = 12,
  parameter int N = 4096,
  localparam int LW = $clog2(N)
) (
  input  logic                clk,
  input  logic                wrEn,
  input  logic [LW-1:0]       wrAddr,
  input  logic signed [W-1:0] wrData,
  input  logic [LW-1:0]       rdAddr,
  output logic signed [W-1:0] rdData
);

  logic signed [W-1:0] store [N];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
    rdData <= store[rdAddr];
  end

endmodule

// File: rtl/xcorr_peak.sv
// Keeps the largest correlation seen since the last clear.
module xcorr_peak #(
  parameter int LW   = 12,
  parameter int ACCW = 36
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clearPeak,
  input  logic                   corrValid,
  input  logic signed [ACCW-1:0] corrVal,
  input  logic [LW-1:0]          corrLag,
  output logic [LW-1:0]          bestLag,
  output logic signed [ACCW-1:0] bestCorr
);

  logic haveBest;
  logic takeNew;

  // Strictly greater: the earliest lag keeps a tie.
  assign takeNew = corrValid && (!haveBest || (corrVal > bestCorr));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      haveBest <= 1'b0;
      bestLag  <= '0;
      bestCorr <= '0;
    end else if (clearPeak) begin
      haveBest <= 1'b0;
    end else if (takeNew) begin
      haveBest <= 1'b1;
      bestLag  <= corrLag;
      bestCorr <= corrVal;
    end
  end

endmodule

// File: rtl/xcorr_datapath.sv
// Record buffers, serial MAC pipeline and peak tracker.
module xcorr_datapath
  import xcorr_pkg::*;
#(
  parameter int W = 12,
  parameter int N = 4096,
  localparam int LW   = $clog2(N),
  localparam int PW   = 2 * W,
  localparam int ACCW = 2 * W + LW
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  xcorrStrobes_t          strb,
  input  logic [LW-1:0]          rdIdx,
  input  logic [LW-1:0]          rdLag,
  input  logic                   ldValid,
  input  logic                   ldFirst,
  input  logic signed [W-1:0]    ldA,
  input  logic signed [W-1:0]    ldB,
  output logic [LW-1:0]          bestLag,
  output logic signed [ACCW-1:0] bestCorr
);

  // ---------------- load side ----------------
  logic [LW-1:0]       wrPtr;
  logic [LW-1:0]       wrAddr;
  logic                wrEn;
  logic signed [W-1:0] wrData [2];
  logic [LW-1:0]       rdAddr [2];
  logic signed [W-1:0] rdData [2];

  assign wrEn      = ldValid && strb.loadEn;
  assign wrAddr    = ldFirst ? '0 : wrPtr;
  assign wrData[0] = ldA;
  assign wrData[1] = ldB;
  assign rdAddr[0] = rdIdx;
  assign rdAddr[1] = rdIdx + rdLag;

  always_ff @(posedge clk) begin
    if (!rstN)     wrPtr <= '0;
    else if (wrEn) wrPtr <= wrAddr + 1'b1;
  end

  for (genvar g = 0; g < 2; g++) begin : gRec
    xcorr_buffer #(.W(W), .N(N)) uRec (
      .clk    (clk),
      .wrEn   (wrEn),
      .wrAddr (wrAddr),
      .wrData (wrData[g]),
      .rdAddr (rdAddr[g]),
      .rdData (rdData[g])
    );
  end

  // ---------------- MAC pipeline ----------------
  // stage 1: buffer read, stage 2: product, stage 3: accumulate
  logic                   v1, f1, l1;
  logic [LW-1:0]          lag1;
  logic                   v2, f2, l2;
  logic [LW-1:0]          lag2;
  logic signed [PW-1:0]   prod2;
  logic                   corrValid3;
  logic [LW-1:0]          lag3;
  logic signed [ACCW-1:0] acc3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      v1 <= 1'b0; f1 <= 1'b0; l1 <= 1'b0; lag1 <= '0;
      v2 <= 1'b0; f2 <= 1'b0; l2 <= 1'b0; lag2 <= '0;
      prod2      <= '0;
      corrValid3 <= 1'b0;
      lag3       <= '0;
      acc3       <= '0;
    end else begin
      v1   <= strb.issue;
      f1   <= strb.firstTerm;
      l1   <= strb.lastTerm;
      lag1 <= rdLag;

      v2    <= v1;
      f2    <= f1;
      l2    <= l1;
      lag2  <= lag1;
      prod2 <= PW'(rdData[0]) * PW'(rdData[1]);

      corrValid3 <= v2 && l2;
      if (v2) begin
        lag3 <= lag2;
        acc3 <= f2 ? ACCW'(prod2) : acc3 + ACCW'(prod2);
      end
    end
  end

  // ---------------- peak search ----------------
  xcorr_peak #(.LW(LW), .ACCW(ACCW)) uPeak (
    .clk       (clk),
    .rstN      (rstN),
    .clearPeak (strb.clearPeak),
    .corrValid (corrValid3),
    .corrVal   (acc3),
    .corrLag   (lag3),
    .bestLag   (bestLag),
    .bestCorr  (bestCorr)
  );

endmodule

// File: rtl/xcorr_ctrl.sv
// Lag/index sequencer: one product term per cycle, then pipeline drain.
module xcorr_ctrl
  import xcorr_pkg::*;
#(
  parameter int N = 4096,
  localparam int LW = $clog2(N),
  localparam int DRAIN_LAST = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [LW-1:0] minLag,
  input  logic [LW-1:0] maxLag,
  output xcorrStrobes_t strb,
  output logic [LW-1:0] rdIdx,
  output logic [LW-1:0] rdLag,
  output logic          busy,
  output logic          done
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} ctrlState_t;

  ctrlState_t    state;
  logic [LW-1:0] lagCnt;
  logic [LW-1:0] idxCnt;
  logic [LW-1:0] endLag;
  logic [1:0]    drainCnt;
  logic [LW-1:0] lastIdx;
  logic          termLast;
  logic          launch;

  assign lastIdx  = LW'(N - 1) - lagCnt;
  assign termLast = (idxCnt == lastIdx);
  assign launch   = start && (state == S_IDLE);

  always_comb begin
    strb.issue     = (state == S_RUN);
    strb.firstTerm = (state == S_RUN) && (idxCnt == '0);
    strb.lastTerm  = (state == S_RUN) && termLast;
    strb.clearPeak = launch;
    strb.loadEn    = (state == S_IDLE);
  end

  assign rdIdx = idxCnt;
  assign rdLag = lagCnt;
  assign busy  = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      lagCnt   <= '0;
      idxCnt   <= '0;
      endLag   <= '0;
      drainCnt <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (launch) begin
            lagCnt <= minLag;
            idxCnt <= '0;
            endLag <= (maxLag < minLag) ? minLag : maxLag;
            state  <= S_RUN;
          end
        end
        S_RUN: begin
          if (termLast) begin
            idxCnt <= '0;
            if (lagCnt == endLag) begin
              drainCnt <= '0;
              state    <= S_DRAIN;
            end else begin
              lagCnt <= lagCnt + 1'b1;
            end
          end else begin
            idxCnt <= idxCnt + 1'b1;
          end
        end
        S_DRAIN: begin
          drainCnt <= drainCnt + 1'b1;
          if (drainCnt == 2'(DRAIN_LAST)) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xcorr_lag_finder.sv
// Top: sequencer plus datapath.
module xcorr_lag_finder
  import xcorr_pkg::*;
#(
  parameter int W = 12,
  parameter int N = 4096,
  localparam int LW   = $clog2(N),
  localparam int ACCW = 2 * W + LW
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   ldValid,
  input  logic                   ldFirst,
  input  logic signed [W-1:0]    ldA,
  input  logic signed [W-1:0]    ldB,
  input  logic                   start,
  input  logic [LW-1:0]          minLag,
  input  logic [LW-1:0]          maxLag,
  output logic                   busy,
  output logic                   done,
  output logic [LW-1:0]          bestLag,
  output logic signed [ACCW-1:0] bestCorr
);

  xcorrStrobes_t strb;
  logic [LW-1:0] rdIdx;
  logic [LW-1:0] rdLag;

  xcorr_ctrl #(.N(N)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .minLag (minLag),
    .maxLag (maxLag),
    .strb   (strb),
    .rdIdx  (rdIdx),
    .rdLag  (rdLag),
    .busy   (busy),
    .done   (done)
  );

  xcorr_datapath #(.W(W), .N(N)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .rdIdx    (rdIdx),
    .rdLag    (rdLag),
    .ldValid  (ldValid),
    .ldFirst  (ldFirst),
    .ldA      (ldA),
    .ldB      (ldB),
    .bestLag  (bestLag),
    .bestCorr (bestCorr)
  );

endmodule

// File: rtl/xcorr_checker.sv
// Protocol and result checks, attached to the top by bind.
module xcorr_checker #(
  parameter int W = 12,
  parameter int N = 4096,
  localparam int LW   = $clog2(N),
  localparam int ACCW = 2 * W + LW
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic [LW-1:0]          minLag,
  input logic [LW-1:0]          maxLag,
  input logic                   busy,
  input logic                   done,
  input logic [LW-1:0]          bestLag,
  input logic signed [ACCW-1:0] bestCorr
);

  // Window captured independently of the sequencer.
  logic [LW-1:0] capMin;
  logic [LW-1:0] capEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capMin <= '0;
      capEnd <= '0;
    end else if (start && !busy) begin
      capMin <= minLag;
      capEnd <= (maxLag < minLag) ? minLag : maxLag;
    end
  end

  // R9: done lasts a single cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: busy only drops together with done
  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: an accepted start raises busy next cycle
  p_start_launch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R11: results hold while idle
  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(bestLag) && $stable(bestCorr)));

  // R4 / R7: reported lag lies inside the captured window
  p_lag_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((bestLag >= capMin) && (bestLag <= capEnd)));

endmodule

bind xcorr_lag_finder xcorr_checker #(.W(W), .N(N)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .minLag   (minLag),
  .maxLag   (maxLag),
  .busy     (busy),
  .done     (done),
  .bestLag  (bestLag),
  .bestCorr (bestCorr)
);

// File: tb/sim_xcorr_lag_finder.sv
`timescale 1ns/1ps
module sim_xcorr_lag_finder;

  localparam int W    = 8;
  localparam int N    = 16;
  localparam int LW   = $clog2(N);
  localparam int ACCW = 2 * W + LW;

  // Vector: {pattern kind[3:0], shift[7:0], minLag[7:0], maxLag[7:0]}
  localparam int NVEC = 6;
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd0, 8'd3, 8'd0,  8'd15},
    {4'd0, 8'd7, 8'd0,  8'd15},
    {4'd0, 8'd5, 8'd2,  8'd9},
    {4'd1, 8'd2, 8'd0,  8'd15},
    {4'd0, 8'd0, 8'd0,  8'd0},
    {4'd2, 8'd4, 8'd1,  8'd12}
  };

  logic                   clk = 1'b0;
  logic                   rstN = 1'b0;
  logic                   ldValid = 1'b0;
  logic                   ldFirst = 1'b0;
  logic signed [W-1:0]    ldA = '0;
  logic signed [W-1:0]    ldB = '0;
  logic                   start = 1'b0;
  logic [LW-1:0]          minLag = '0;
  logic [LW-1:0]          maxLag = '0;
  logic                   busy;
  logic                   done;
  logic [LW-1:0]          bestLag;
  logic signed [ACCW-1:0] bestCorr;

  int checks = 0;
  int errors = 0;

  logic signed [W-1:0] aM [N];
  logic signed [W-1:0] bM [N];

  always #2.5 clk = ~clk;

  xcorr_lag_finder #(.W(W), .N(N)) u0 (
    .clk(clk), .rstN(rstN), .ldValid(ldValid), .ldFirst(ldFirst),
    .ldA(ldA), .ldB(ldB), .start(start), .minLag(minLag), .maxLag(maxLag),
    .busy(busy), .done(done), .bestLag(bestLag), .bestCorr(bestCorr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [W-1:0] gen(input int kind, input int i);
    int v;
    case (kind)
      1:       v = (i % 2 == 1) ? (-100 + i) : (90 - i);
      2:       v = i * 9 - 60;
      default: v = ((i * 29 + 7) ^ (i * i * 3)) & 255;
    endcase
    return W'(v);
  endfunction

  task automatic fillPattern(input int kind, input int shift);
    for (int i = 0; i < N; i++) aM[i] = gen(kind, i);
    for (int i = 0; i < N; i++)
      bM[i] = (i >= shift) ? aM[i - shift] : gen(kind, i + 40);
  endtask

  function automatic void model(input int minL, input int maxL,
                                output int eLag, output longint eCorr);
    int  endL;
    bit  have;
    longint c;
    endL  = (maxL < minL) ? minL : maxL;
    have  = 1'b0;
    eLag  = 0;
    eCorr = 0;
    for (int l = minL; l <= endL; l++) begin
      c = 0;
      for (int i = 0; i < N - l; i++)
        c += longint'(aM[i]) * longint'(bM[i + l]);
      if (!have || c > eCorr) begin
        have  = 1'b1;
        eLag  = l;
        eCorr = c;
      end
    end
  endfunction

  function automatic int terms(input int minL, input int maxL);
    int endL, t;
    endL = (maxL < minL) ? minL : maxL;
    t = 0;
    for (int l = minL; l <= endL; l++) t += N - l;
    return t;
  endfunction

  task automatic loadRecords(input bit first);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ldValid = 1'b1;
      ldFirst = first && (i == 0);
      ldA = aM[i];
      ldB = bM[i];
    end
    @(negedge clk);
    ldValid = 1'b0;
    ldFirst = 1'b0;
  endtask

  task automatic loadGarbage(input int count);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      ldValid = 1'b1;
      ldFirst = (i == 0);
      ldA = W'(55 + i);
      ldB = W'(-3 * i);
    end
    @(negedge clk);
    ldValid = 1'b0;
    ldFirst = 1'b0;
  endtask

  // Runs one search and checks result and latency against the model.
  task automatic doSearch(input int minL, input int maxL, input bit poke,
                          input string req);
    int n, eLag, t;
    longint eCorr;
    model(minL, maxL, eLag, eCorr);
    t = terms(minL, maxL);
    @(negedge clk);
    start  = 1'b1;
    minLag = LW'(minL);
    maxLag = LW'(maxL);
    @(negedge clk);              // cycle s+1
    start  = 1'b0;
    minLag = LW'(minL + 3);      // window must already be captured (R7)
    maxLag = '0;
    n = 1;
    chk(busy === 1'b1, "R8", "busy after start", longint'(busy), 1);
    while (done !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
      if (poke && n == 5) begin
        start = 1'b1; ldValid = 1'b1; ldFirst = 1'b1;
        ldA = W'(77); ldB = W'(-77);
      end
      if (poke && n == 6) begin
        start = 1'b0; ldValid = 1'b0; ldFirst = 1'b0;
      end
    end
    chk(n == t + 4, "R9", "done cycle after start", n, t + 4);
    chk(busy === 1'b0, "R8", "busy low with done", longint'(busy), 0);
    chk(int'(bestLag) == eLag, req, "bestLag", longint'(bestLag), eLag);
    chk(longint'(bestCorr) == eCorr, req, "bestCorr", longint'(bestCorr), eCorr);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done single cycle", longint'(done), 0);
  endtask

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int holdLag;
    longint holdCorr;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R10", "busy/done in reset", longint'({busy, done}), 0);
    chk(bestLag === '0 && bestCorr === '0, "R10", "results in reset", longint'(bestCorr), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && bestLag === '0, "R10", "after reset", longint'(bestLag), 0);

    // Table-driven main function (R4)
    for (int v = 0; v < NVEC; v++) begin
      fillPattern(int'(VEC[v][27:24]), int'(VEC[v][23:16]));
      loadRecords(1'b1);
      doSearch(int'(VEC[v][15:8]), int'(VEC[v][7:0]), 1'b0, "R4");
    end

    // R5: tie between lag 2 and lag 7, earliest wins
    for (int i = 0; i < N; i++) begin aM[i] = '0; bM[i] = '0; end
    aM[0] = 8'sd1; bM[2] = 8'sd5; bM[7] = 8'sd5;
    loadRecords(1'b1);
    doSearch(0, 15, 1'b0, "R5");
    chk(bestLag == LW'(2), "R5", "tie resolves to lag 2", longint'(bestLag), 2);

    // R6: every sum negative, least negative at lag 15 (-1)
    for (int i = 0; i < N; i++) begin aM[i] = 8'sd1; bM[i] = -8'sd1; end
    loadRecords(1'b1);
    doSearch(0, 15, 1'b0, "R6");
    chk(longint'(bestCorr) == -1, "R6", "least negative sum", longint'(bestCorr), -1);

    // R3: full-scale records, no overflow
    for (int i = 0; i < N; i++) begin aM[i] = -8'sd128; bM[i] = -8'sd128; end
    loadRecords(1'b1);
    doSearch(0, 0, 1'b0, "R3");
    chk(longint'(bestCorr) == 262144, "R3", "max positive sum", longint'(bestCorr), 262144);
    for (int i = 0; i < N; i++) bM[i] = 8'sd127;
    loadRecords(1'b1);
    doSearch(0, 3, 1'b0, "R3");

    // R7: reversed window evaluates minLag only
    fillPattern(0, 6);
    loadRecords(1'b1);
    doSearch(9, 4, 1'b0, "R7");

    // R2 / R8: start and load beats during a run are ignored
    doSearch(0, 15, 1'b1, "R8");
    doSearch(0, 15, 1'b0, "R2");

    // R11: results hold while idle
    holdLag  = int'(bestLag);
    holdCorr = longint'(bestCorr);
    repeat (5) @(negedge clk);
    chk(int'(bestLag) == holdLag && longint'(bestCorr) == holdCorr, "R11",
        "results while idle", longint'(bestCorr), holdCorr);

    // R1: pointer wrap, then re-anchor with ldFirst
    fillPattern(0, 11);
    loadGarbage(N);              // pointer wraps back to 0
    loadRecords(1'b0);           // lands at 0..N-1 through the wrap
    doSearch(0, 15, 1'b0, "R1");
    loadGarbage(5);
    loadRecords(1'b1);           // ldFirst re-anchors to address 0
    doSearch(0, 15, 1'b0, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule